// File: doc/BRIEF.md
# Four-Channel Compare-Match System Timer

This block is a memory-mapped system timer. A wide free-running counter advances by one on every clock cycle in which the tick-enable input is high. By default the counter is 64 bits wide, and it is seen by software as a low word and a high word. Four compare channels each hold a value as wide as the low word. When a tick carries the low word onto a channel's value, that channel's match flag is set. The flag drives the channel's own interrupt line and stays set until software clears it.

Software arms a one-shot delay in three steps. It reads the low word, adds an interval, and writes the sum to a compare register. The sum may wrap past the top of the low word, and the match still lands correctly, because the comparison only ever looks at the low word. A control/status word collects the four flags. Writing ones to it clears the selected flags, so a single access can clear any subset of them.

The register bus is a plain single-cycle 32-bit interface. A write takes effect at the clock edge where the write strobe is sampled. A read returns its data on `rdata` from the following cycle onward. Accesses that are not word aligned, or that fall outside the map, are ignored.

Top module: `quad_match_timer`

## Requirements
- R1: After a synchronous reset, the counter, all compare registers and all flags are zero, `irq` is 4'b0000 and `rdata` is zero.
- R2: The counter increases by exactly one at each clock edge where `tick_en` is high and holds otherwise. A carry out of the low word increments the high word. The low word reads at byte offset 0x04 and the high word at 0x08.
- R3: Compare channels 0, 1, 2 and 3 are read/write registers at byte offsets 0x0C, 0x10, 0x14 and 0x18.
- R4: Flag i is set at the clock edge where a tick moves the low word to a value equal to compare register i. The comparison is modulo 2^LO_W, so a target that wrapped past the top of the low word still matches. No flag is set without a tick.
- R5: Once set, a flag stays set while the counter moves on past the compare value, until it is cleared by software.
- R6: The status word at offset 0x00 shows flag i in bit i. Writing 1 to bit i clears flag i, writing 0 to a bit leaves that flag unchanged, and writing 0xF clears all four flags.
- R7: If a clear of flag i and a match on channel i happen at the same clock edge, flag i ends up set.
- R8: `irq[i]` is the registered level of flag i. It falls at the same edge that performs the clear.
- R9: Writes to the counter words at offsets 0x04 and 0x08 are ignored.
- R10: `rdata` is loaded at the edge that samples `rd_en` and holds the register value from just before that edge. Between reads, `rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advances the counter by one on each cycle it is high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address; must be word aligned |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq | output | N_CH | One interrupt level per compare channel |

## Verification
Every result of this block is due one clock edge after its stimulus:
- A write, a tick, a match or a clear becomes visible in `irq`, and in the next status read, right after the edge that samples it.
- Read data appears after the edge that samples `rd_en`.

The bench drives all inputs on the falling edge and lets exactly that many rising edges pass. It then samples on the next falling edge, so no check is made in the cycle of its own stimulus. A separate bench model counts ticks, which gives the expected counter words and the exact tick on which each flag must rise. The bench shrinks the low word to 10 bits, so the carry into the high word and a wrapped compare target can both be reached in about a thousand cycles.

// File: rtl/qmt_pkg.sv
package qmt_pkg;
  // Word indices on the register bus (byte offset / 4)
  localparam int IDX_STAT = 0;
  localparam int IDX_LO   = 1;
  localparam int IDX_HI   = 2;
  localparam int IDX_CMP0 = 3;
endpackage

// File: rtl/qmt_counter.sv
module qmt_counter #(
  parameter int LO_W = 32,
  parameter int HI_W = 32,
  localparam int CNT_W = LO_W + HI_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count_q,
  output logic [LO_W-1:0]  lo_next
);
  always_ff @(posedge clk) begin
    if (rst)          count_q <= '0;
    else if (tick_en) count_q <= count_q + CNT_W'(1);
  end

  // Low word the next tick will produce (wraps modulo 2^LO_W)
  assign lo_next = count_q[LO_W-1:0] + LO_W'(1);
endmodule

// File: rtl/qmt_channel.sv
module qmt_channel #(
  parameter int LO_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick_en,
  input  logic [LO_W-1:0] lo_next,
  input  logic            cmp_we,
  input  logic [LO_W-1:0] cmp_wdata,
  input  logic            clr,
  output logic [LO_W-1:0] cmp_q,
  output logic            flag_q
);
  logic hit;

  // Equality is reached at the edge where the tick lands on the compare value
  assign hit = tick_en && (lo_next == cmp_q);

  always_ff @(posedge clk) begin
    if (rst)         cmp_q <= '0;
    else if (cmp_we) cmp_q <= cmp_wdata;
  end

  // Set wins over clear
  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= hit | (flag_q & ~clr);
  end
endmodule

// File: rtl/qmt_decode.sv
module qmt_decode
  import qmt_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int N_CH   = 4,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              stat_we,
  output logic [N_CH-1:0]   cmp_we,
  output logic              rd_hit,
  output logic [WORD_W-1:0] word
);
  logic aligned;

  assign aligned = (addr[1:0] == 2'b00);
  assign word    = addr[ADDR_W-1:2];
  assign stat_we = wr_en && aligned && (word == WORD_W'(IDX_STAT));
  assign rd_hit  = rd_en && aligned;

  for (genvar g = 0; g < N_CH; g++) begin : g_we
    assign cmp_we[g] = wr_en && aligned && (word == WORD_W'(IDX_CMP0 + g));
  end
endmodule

// File: rtl/quad_match_timer.sv
module quad_match_timer
  import qmt_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int LO_W   = 32,
  parameter int HI_W   = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  localparam int CNT_W  = LO_W + HI_W,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [N_CH-1:0]   irq
);
  logic [CNT_W-1:0]  count_q;
  logic [LO_W-1:0]   lo_next;
  logic              stat_we;
  logic [N_CH-1:0]   cmp_we;
  logic              rd_hit;
  logic [WORD_W-1:0] word;
  logic [N_CH-1:0]   flag_q;
  logic [LO_W-1:0]   cmp_q [N_CH];
  logic [DATA_W-1:0] rd_d;

  qmt_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .count_q(count_q), .lo_next(lo_next)
  );

  qmt_decode #(.ADDR_W(ADDR_W), .N_CH(N_CH)) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .stat_we(stat_we), .cmp_we(cmp_we), .rd_hit(rd_hit), .word(word)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    qmt_channel #(.LO_W(LO_W)) u_ch (
      .clk(clk), .rst(rst), .tick_en(tick_en), .lo_next(lo_next),
      .cmp_we(cmp_we[g]), .cmp_wdata(wdata[LO_W-1:0]),
      .clr(stat_we && wdata[g]),
      .cmp_q(cmp_q[g]), .flag_q(flag_q[g])
    );
  end

  assign irq = flag_q;

  always_comb begin
    rd_d = '0;
    if (word == WORD_W'(IDX_STAT))    rd_d[N_CH-1:0] = flag_q;
    else if (word == WORD_W'(IDX_LO)) rd_d[LO_W-1:0] = count_q[LO_W-1:0];
    else if (word == WORD_W'(IDX_HI)) rd_d[HI_W-1:0] = count_q[CNT_W-1:LO_W];
    for (int i = 0; i < N_CH; i++) begin
      if (word == WORD_W'(IDX_CMP0 + i)) rd_d[LO_W-1:0] = cmp_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_hit) rdata <= rd_d;
  end
endmodule

// File: rtl/qmt_checker.sv
module qmt_checker #(
  parameter int N_CH   = 4,
  parameter int LO_W   = 32,
  parameter int HI_W   = 32,
  parameter int ADDR_W = 5,
  localparam int CNT_W  = LO_W + HI_W,
  localparam int WORD_W = ADDR_W - 2
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [N_CH-1:0]   wbits,
  input logic [N_CH-1:0]   irq,
  input logic [CNT_W-1:0]  count_q
);
  logic stat_wr;
  assign stat_wr = wr_en && (addr == '0);

  // R1: reset empties counter and interrupt lines
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (count_q == '0) && (irq == '0));

  // R2: one step per tick, otherwise hold
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> count_q == CNT_W'($past(count_q) + CNT_W'(1)));
  a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(count_q));

  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    // R4: no flag appears without a tick
    a_r4_no_tick_no_set: assert property (@(posedge clk) disable iff (rst)
      (!irq[g] && !tick_en) |=> !irq[g]);
    // R5/R6: a flag only falls through a write of 1 to its status bit
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      (irq[g] && !(stat_wr && wbits[g])) |=> irq[g]);
    // R8: clearing with no tick drops the line at the next edge
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
      (stat_wr && wbits[g] && !tick_en) |=> !irq[g]);
  end
endmodule

bind quad_match_timer qmt_checker #(
  .N_CH(N_CH), .LO_W(LO_W), .HI_W(HI_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
  .wbits(wdata[N_CH-1:0]), .irq(irq), .count_q(count_q)
);

// File: tb/quad_match_timer_bench.sv
module quad_match_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH   = 4;
  localparam int LO_W   = 10;
  localparam int HI_W   = 22;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam longint LO_M = (64'd1 << LO_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic [N_CH-1:0]   irq;

  int checks = 0;
  int fails  = 0;
  longint exp_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_match_timer #(.N_CH(N_CH), .LO_W(LO_W), .HI_W(HI_W),
                     .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_quad_match_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=0x%h exp=0x%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
    exp_cnt += n;
  endtask

  function automatic logic [31:0] lo_exp();
    return 32'(exp_cnt & LO_M);
  endfunction
  function automatic logic [31:0] hi_exp();
    return 32'(exp_cnt >> LO_W);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 rdata after reset", rdata, 32'h0);
    chk("R1 irq after reset", {28'h0, irq}, 32'h0);
    for (int w = 0; w < 7; w++) begin
      bus_rd(ADDR_W'(w * 4), v);
      chk("R1 register zero after reset", v, 32'h0);
    end
  endtask

  task automatic t_count();
    logic [31:0] v;
    run_ticks(37);
    bus_rd(5'h04, v); chk("R2 low word after 37 ticks", v, lo_exp());
    bus_rd(5'h08, v); chk("R2 high word before carry", v, 32'h0);
    // R10: read sampled at the same edge as a tick returns the pre-edge value
    @(negedge clk); tick_en = 1'b1; rd_en = 1'b1; addr = 5'h04;
    @(negedge clk); tick_en = 1'b0; rd_en = 1'b0;
    chk("R10 read returns value before the edge", rdata, lo_exp());
    exp_cnt += 1;
    repeat (3) @(negedge clk);
    chk("R10 rdata holds between reads", rdata, 32'(lo_exp() - 1));
    bus_rd(5'h04, v); chk("R2 low word after extra tick", v, lo_exp());
    run_ticks(1024 - 38 + 5);
    bus_rd(5'h04, v); chk("R2 low word after carry", v, lo_exp());
    bus_rd(5'h08, v); chk("R2 carry into high word", v, hi_exp());
  endtask

  task automatic t_regs();
    logic [31:0] v;
    for (int i = 0; i < N_CH; i++) bus_wr(ADDR_W'(12 + 4 * i), 32'(10'h155 + 33 * i));
    for (int i = 0; i < N_CH; i++) begin
      bus_rd(ADDR_W'(12 + 4 * i), v);
      chk("R3 compare readback", v, 32'(10'h155 + 33 * i));
    end
    bus_wr(5'h04, 32'h55); bus_wr(5'h08, 32'h77);
    bus_rd(5'h04, v); chk("R9 low word write ignored", v, lo_exp());
    bus_rd(5'h08, v); chk("R9 high word write ignored", v, hi_exp());
  endtask

  task automatic t_match();
    logic [31:0] v;
    longint c = exp_cnt;
    bus_wr(5'h0C, 32'((c + 100) & LO_M));
    bus_wr(5'h10, 32'((c + 5) & LO_M));
    bus_wr(5'h14, 32'((c + 200) & LO_M));
    bus_wr(5'h18, 32'((c + 8) & LO_M));
    bus_wr(5'h00, 32'hF);
    bus_rd(5'h00, v); chk("R6 all flags cleared by 0xF", v, 32'h0);
    run_ticks(4);
    chk("R4 no flag before reaching compare", {28'h0, irq}, 32'h0);
    run_ticks(1);
    chk("R4 channel 1 irq on matching tick", {28'h0, irq}, 32'h2);
    bus_rd(5'h00, v); chk("R4 status bit 1 set", v, 32'h2);
    run_ticks(5);
    bus_rd(5'h00, v); chk("R5 flags sticky past compare", v, 32'hA);
    bus_wr(5'h00, 32'h0);
    bus_rd(5'h00, v); chk("R6 writing 0 leaves flags", v, 32'hA);
    bus_wr(5'h00, 32'h2);
    chk("R8 irq 1 drops at the clearing edge", {28'h0, irq}, 32'h8);
    bus_rd(5'h00, v); chk("R6 single clear", v, 32'h8);
    bus_wr(5'h00, 32'hF);
    bus_rd(5'h00, v); chk("R6 0xF clears remaining", v, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    bus_wr(5'h0C, 32'((exp_cnt + 1) & LO_M));
    @(negedge clk); wr_en = 1'b1; addr = 5'h00; wdata = 32'h1; tick_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick_en = 1'b0;
    exp_cnt += 1;
    chk("R7 match beats clear on irq", {28'h0, irq}, 32'h1);
    bus_rd(5'h00, v); chk("R7 match beats clear on status", v, 32'h1);
    bus_wr(5'h00, 32'h1);
    chk("R8 irq 0 low after clear", {28'h0, irq}, 32'h0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    run_ticks(int'((1000 - (exp_cnt & LO_M) + 1024) & LO_M));
    bus_wr(5'h0C, 32'd500); bus_wr(5'h10, 32'd500); bus_wr(5'h18, 32'd500);
    bus_wr(5'h14, 32'((1000 + 50) & LO_M));
    bus_wr(5'h00, 32'hF);
    run_ticks(49);
    bus_rd(5'h00, v); chk("R4 wrapped target not hit early", v, 32'h0);
    bus_rd(5'h08, v); chk("R2 high word after wrap", v, hi_exp());
    run_ticks(1);
    bus_rd(5'h00, v); chk("R4 wrapped target matches", v, 32'h4);
    chk("R8 irq 2 follows flag", {28'h0, irq}, 32'h4);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_regs();
    t_match();
    t_collide();
    t_wrap();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule